// File: doc/BRIEF.md
# Step-Composed Sixteen-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for 16-bit two's-complement words. It is not driven by an opcode that is decoded into a list of operations. Six independent control bits each switch on one simple step in a fixed chain. Each operand may be cleared and then inverted. The two conditioned operands are then either added or ANDed. The result may then be inverted. Chaining these steps gives eighteen useful functions: constants, pass-through, negation, increment, decrement, sum, both differences, AND and OR.

Two flags come from the final result. One reports an all-zero word and one reports a negative word. Addition wraps modulo 2^16, and no carry or overflow indication leaves the block. The block has no clock and no reset. Its outputs follow its inputs within one evaluation.

Top module: `alu_step_chain`

## Requirements
- R1: Control bit `ctrl_i[5]` (clear-x) replaces operand x with zero before any other step. While it is set, the value on `x_i` has no effect on any output.
- R2: Control bit `ctrl_i[4]` (invert-x) inverts every bit of the operand x, and this happens after the clear-x step.
- R3: Control bits `ctrl_i[3]` (clear-y) and `ctrl_i[2]` (invert-y) act on operand y in that same order: clear first, then invert.
- R4: Control bit `ctrl_i[1]` selects the combining step. With 1 the conditioned operands are added, and the carry out of bit 15 is dropped so the sum wraps modulo 2^16. With 0 they are combined by bitwise AND.
- R5: Control bit `ctrl_i[0]` inverts every bit of the combined word, and this is the last step before `res_o`.
- R6: Each of the eighteen codes on `ctrl_i[5:0]` gives its function. The codes are: 101010 gives 0, 111111 gives 1, 111010 gives -1, 001100 gives x, 110000 gives y, 001101 gives NOT x, 110001 gives NOT y, 001111 gives -x, 110011 gives -y, 011111 gives x+1, 110111 gives y+1, 001110 gives x-1, 110010 gives y-1, 000010 gives x+y, 010011 gives x-y, 000111 gives y-x, 000000 gives x AND y, and 010101 gives x OR y.
- R7: `zero_o` is 1 exactly when all 16 bits of `res_o` are 0.
- R8: `neg_o` is 1 exactly when bit 15 of `res_o` is 1, which marks a negative two's-complement value.
- R9: The block holds no state. A change on any input reaches `res_o`, `zero_o` and `neg_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | First operand, two's complement |
| y_i | input | 16 | Second operand, two's complement |
| ctrl_i | input | 6 | Step controls: [5] clear-x, [4] invert-x, [3] clear-y, [2] invert-y, [1] add(1)/AND(0), [0] invert result |
| res_o | output | 16 | Result word |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Bit 15 of the result |

## Verification
The hardest cases to reach from the ports are those where the carry chain runs across the whole word: a sum that wraps from 0xFFFF to zero, the step from 0x7FFF into 0x8000, and the negation of 0x8000, which gives 0x8000 back. Random operands almost never land on these. The stimulus therefore mixes a fixed set of edge operands (0, 1, 0x7FFF, 0x8000 and 0xFFFF) into every pair. It also checks the clear-x code while the x input toggles between extreme values, to show that x cannot leak into any output.

// File: rtl/alu_step_pkg.sv
package alu_step_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CTRL_W = 6;

  typedef struct packed {
    logic clr_x;
    logic inv_x;
    logic clr_y;
    logic inv_y;
    logic do_sum;
    logic inv_res;
  } step_ctrl_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] opnd_i,
  input  logic         clear_i,
  input  logic         invert_i,
  output logic [W-1:0] opnd_o
);
  logic [W-1:0] cleared;

  always_comb begin
    cleared = clear_i ? '0 : opnd_i;
    opnd_o  = invert_i ? ~cleared : cleared;
  end
endmodule

// File: rtl/alu_combine.sv
module alu_combine #(
  parameter int unsigned W         = 16,
  parameter bit          RIPPLE_FA = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sum_sel_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sum_w;

  generate
    if (RIPPLE_FA) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_fa
        logic half_s;
        assign half_s     = a_i[i] ^ b_i[i];
        assign sum_w[i]   = half_s ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_i[i]) | (half_s & carry[i]);
      end
      logic carry_drop;
      assign carry_drop = carry[W];
    end else begin : g_behav
      assign sum_w = a_i + b_i;
    end
  endgenerate

  assign word_o = sum_sel_i ? sum_w : (a_i & b_i);
endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word_i,
  input  logic         invert_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    res_o  = invert_i ? ~word_i : word_i;
    zero_o = ~|res_o;
    neg_o  = res_o[MSB];
  end
endmodule

// File: rtl/alu_step_chain.sv
module alu_step_chain
  import alu_step_pkg::*;
(
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WORD_W-1:0] res_o,
  output logic              zero_o,
  output logic              neg_o
);
  step_ctrl_t        stp;
  logic [WORD_W-1:0] x_prep;
  logic [WORD_W-1:0] y_prep;
  logic [WORD_W-1:0] comb_word;

  assign stp = step_ctrl_t'(ctrl_i);

  alu_operand_prep #(.W(WORD_W)) x_prep_i (
    .opnd_i(x_i), .clear_i(stp.clr_x), .invert_i(stp.inv_x), .opnd_o(x_prep)
  );

  alu_operand_prep #(.W(WORD_W)) y_prep_i (
    .opnd_i(y_i), .clear_i(stp.clr_y), .invert_i(stp.inv_y), .opnd_o(y_prep)
  );

  alu_combine #(.W(WORD_W), .RIPPLE_FA(1'b1)) combine_i (
    .a_i(x_prep), .b_i(y_prep), .sum_sel_i(stp.do_sum), .word_o(comb_word)
  );

  alu_result_stage #(.W(WORD_W)) result_i (
    .word_i(comb_word), .invert_i(stp.inv_res),
    .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  logic [WORD_W-1:0] sum_ref;
  always_comb begin
    sum_ref = x_i + y_i;
    AST_FLAGS_DISJOINT: assert (!(zero_o && neg_o)); // R7
    if (ctrl_i == 6'b101010) begin
      AST_CLR_X_ZERO: assert (res_o == '0 && zero_o); // R1
    end
    if (ctrl_i == 6'b000010) begin
      AST_SUM_WRAPS: assert (res_o == sum_ref); // R4
    end
    if (ctrl_i == 6'b000000) begin
      AST_AND_SUBSET: assert ((res_o & ~x_i) == '0); // R4
    end
    if (ctrl_i == 6'b001101) begin
      AST_INV_RES_LAST: assert (res_o == ~x_i); // R5
    end
    if (ctrl_i == 6'b001100) begin
      AST_PASS_X: assert (res_o == x_i); // R6
    end
  end
endmodule

// File: tb/alu_step_chain_tb_top.sv
module alu_step_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 24;

  localparam logic [5:0] CODES [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101
  };
  localparam logic [15:0] EDGES [6] = '{
    16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5A3C
  };

  logic        clk = 1'b0;
  logic [15:0] x_s = '0;
  logic [15:0] y_s = '0;
  logic [5:0]  c_s = '0;
  logic [15:0] res_w;
  logic        zero_w;
  logic        neg_w;
  int          errors = 0;
  int          checks = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_step_chain dut_i (
    .x_i(x_s), .y_i(y_s), .ctrl_i(c_s),
    .res_o(res_w), .zero_o(zero_w), .neg_o(neg_w)
  );

  function automatic logic [15:0] ref_fn(int idx, logic [15:0] x, logic [15:0] y);
    case (idx)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return x;
      4: return y;
      5: return ~x;
      6: return ~y;
      7: return 16'(-x);
      8: return 16'(-y);
      9: return 16'(x + 16'd1);
      10: return 16'(y + 16'd1);
      11: return 16'(x - 16'd1);
      12: return 16'(y - 16'd1);
      13: return 16'(x + y);
      14: return 16'(x - y);
      15: return 16'(y - x);
      16: return x & y;
      default: return x | y;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ctrl=%b x=%h y=%h actual=%h expected=%h", req, c_s, x_s, y_s, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] c, logic [15:0] x, logic [15:0] y);
    @(posedge clk);
    c_s = c; x_s = x; y_s = y;
    @(negedge clk);
  endtask

  task automatic full_chk(string req, logic [15:0] exp);
    chk(req, res_w, exp);
    chk("R7", {15'd0, zero_w}, {15'd0, exp == 16'h0});
    chk("R8", {15'd0, neg_w}, {15'd0, exp[15]});
  endtask

  initial begin
    // R9: no clock or reset; outputs valid from the start with zero inputs (x AND y = 0)
    #1;
    full_chk("R9", 16'h0000);

    // R6: every code against the reference, edge and random operands
    for (int k = 0; k < 18; k++) begin
      for (int e = 0; e < 6; e++) begin
        apply(CODES[k], EDGES[e], EDGES[5 - e]);
        full_chk("R6", ref_fn(k, x_s, y_s));
      end
      for (int r = 0; r < N_RAND; r++) begin
        apply(CODES[k], 16'($urandom), 16'($urandom));
        full_chk("R6", ref_fn(k, x_s, y_s));
      end
    end

    // R1: clear-x makes x irrelevant
    apply(6'b100010, 16'hFFFF, 16'h1234); full_chk("R1", 16'h1234);
    apply(6'b100010, 16'h8000, 16'h1234); full_chk("R1", 16'h1234);
    // R2: clear then invert gives all ones
    apply(6'b110000, 16'h0F0F, 16'hAAAA); full_chk("R2", 16'hAAAA);
    apply(6'b110010, 16'h0F0F, 16'h0003); full_chk("R2", 16'h0002);
    // R3: clear-y then invert-y, AND with x passes x
    apply(6'b001100, 16'hC3C3, 16'hFFFF); full_chk("R3", 16'hC3C3);
    apply(6'b000100, 16'hC3C3, 16'h00FF); full_chk("R3", 16'hC300);
    // R4: wraparound corners
    apply(6'b000010, 16'hFFFF, 16'h0001); full_chk("R4", 16'h0000);
    apply(6'b000010, 16'h7FFF, 16'h0001); full_chk("R4", 16'h8000);
    apply(6'b001111, 16'h8000, 16'h0000); full_chk("R4", 16'h8000);
    apply(6'b000000, 16'hF0F0, 16'h3C3C); full_chk("R4", 16'h3030);
    // R5: output inversion
    apply(6'b000011, 16'h0001, 16'h0001); full_chk("R5", 16'hFFFD);
    // R9: input change without clock edge propagates
    @(negedge clk);
    c_s = 6'b001100; x_s = 16'h4321;
    #1;
    full_chk("R9", 16'h4321);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule